// File: doc/BRIEF.md
# Supply margining trim controller

This block is the digital servo behind supply margining. On request it moves a power converter's output toward a stored margin-high or margin-low target and then keeps it there. It compares a 10-bit reading of the converter's differential output voltage against the selected target. The reading arrives one sample at a time over a ready/valid handshake. After each reading the block moves an 8-bit DAC code one step up or down. When the reading equals the target, it freezes the code. While it is margining, the trim output is enabled. When margining stops, the trim output is released to high impedance so that the converter returns to its nominal set point.

A request comes from either of two active-high pins (raise and lower) or from a 2-bit register command. The targets, the start code, the trim polarity and the active level of the ready flag are configuration inputs, written by the host into registers outside this block. The controller is a three-state machine: IDLE (released), SEEK (stepping), HOLD (frozen). Its transitions are named as follows:
- start: IDLE to SEEK.
- lock: SEEK to HOLD.
- retarget: HOLD to SEEK.
- release: SEEK or HOLD to IDLE.

Top module: `margin_trim_ctrl`

## Requirements
- R1: After reset the trim output enable is 0, the DAC code is 0, the ADC ready output is 0 and the settled flag shows its inactive level.
- R2: In IDLE, a valid request causes the start transition. On the next clock edge the trim enable goes to 1 and the DAC code is loaded with `start_code_i`.
- R3: In SEEK, the block takes exactly one step per accepted sample (`adc_valid_i` high while `adc_ready_o` is high). With normal polarity, a reading below the target increments the code and a reading above it decrements the code. With no accepted sample, the code is unchanged.
- R4: With `trim_inv_i`=1 the step direction is reversed: a reading below the target decrements the code.
- R5: The code saturates at 255 and at 0; it never wraps.
- R6: An accepted reading equal to the target causes the lock transition. In HOLD the code is frozen, `adc_ready_o` is 0 and samples have no effect.
- R7: The settled flag is active only in HOLD. With `ready_pol_i`=1 it is active high; with `ready_pol_i`=0 it is active low.
- R8: If no valid request is present in SEEK or HOLD, the release transition occurs on the next edge and the trim enable drops to 0.
- R9: A request for both directions at once (both pins together, or one pin plus the opposite command) counts as no request.
- R10: In HOLD, a change of the selected target value or of the request direction causes the retarget transition to SEEK. The code is kept, not reloaded.
- R11: A raise request selects `tgt_hi_i` and a lower request selects `tgt_lo_i`. The command `margin_cmd_i` encodes 01 as raise, 10 as lower, and 00 or 11 as no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_up_i | input | 1 | Raise request pin, active high |
| pin_dn_i | input | 1 | Lower request pin, active high |
| margin_cmd_i | input | 2 | Register command: 01 raise, 10 lower, else none |
| tgt_hi_i | input | 10 | Margin-high target |
| tgt_lo_i | input | 10 | Margin-low target |
| start_code_i | input | 8 | Code loaded on start (register default 128) |
| trim_inv_i | input | 1 | Reverse step direction |
| ready_pol_i | input | 1 | 1: settled flag active high, 0: active low |
| adc_valid_i | input | 1 | ADC sample valid |
| adc_data_i | input | 10 | ADC reading of the differential output |
| adc_ready_o | output | 1 | Sample accepted (high in SEEK) |
| dac_code_o | output | 8 | Trim DAC code |
| trim_oe_o | output | 1 | Trim driver enable; 0 means high impedance |
| ready_o | output | 1 | Settled flag |

## Verification
The bench builds the block with its default widths: a 10-bit reading and an 8-bit code. With an 8-bit code, runs of a few dozen one-sided samples from a start code near either end reach both saturation limits. Random request changes are mixed with readings placed within a few LSBs of the active target, so lock, retarget and release all occur many times. Both trim polarities and both ready levels are used.

// File: rtl/mtc_pkg.sv
`timescale 1ns/1ps
package mtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEEK = 2'd1,
        ST_HOLD = 2'd2
    } mtc_state_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2
    } mtc_dir_e;

    localparam logic [1:0] CMD_RAISE = 2'b01;
    localparam logic [1:0] CMD_LOWER = 2'b10;
endpackage

// File: rtl/mtc_req_arb.sv
`timescale 1ns/1ps
module mtc_req_arb
    import mtc_pkg::*;
#(
    parameter int ADC_W = 10
) (
    input  logic             pin_up,
    input  logic             pin_dn,
    input  logic [1:0]       cmd,
    input  logic [ADC_W-1:0] tgt_hi,
    input  logic [ADC_W-1:0] tgt_lo,
    output mtc_dir_e         dir,
    output logic [ADC_W-1:0] tgt_sel
);
    logic want_up;
    logic want_dn;

    assign want_up = pin_up | (cmd == CMD_RAISE);
    assign want_dn = pin_dn | (cmd == CMD_LOWER);

    // R9: conflicting requests resolve to none; R11: target follows direction
    always_comb begin
        dir = DIR_NONE;
        if (want_up && !want_dn) begin
            dir = DIR_UP;
        end else if (want_dn && !want_up) begin
            dir = DIR_DN;
        end
        tgt_sel = (dir == DIR_DN) ? tgt_lo : tgt_hi;
    end
endmodule

// File: rtl/mtc_code_step.sv
`timescale 1ns/1ps
module mtc_code_step #(
    parameter int DAC_W = 8,
    parameter int ADC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DAC_W-1:0] start_code,
    input  logic             step_en,
    input  logic [ADC_W-1:0] sample,
    input  logic [ADC_W-1:0] target,
    input  logic             inv,
    output logic [DAC_W-1:0] code,
    output logic             match,
    output logic             go_up
);
    localparam logic [DAC_W-1:0] CODE_MAX = {DAC_W{1'b1}};
    localparam logic [DAC_W-1:0] CODE_MIN = '0;

    logic [DAC_W-1:0] code_q;
    logic [DAC_W-1:0] code_d;
    logic             below;

    assign below = sample < target;
    assign match = sample == target;
    assign go_up = below ^ inv;     // R3, R4

    always_comb begin
        code_d = code_q;
        if (load) begin
            code_d = start_code;
        end else if (step_en) begin
            if (go_up) begin
                if (code_q != CODE_MAX) code_d = code_q + 1'b1;
            end else begin
                if (code_q != CODE_MIN) code_d = code_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign code = code_q;

    // R5: no wrap at either end
    a_r5_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && go_up && code_q == CODE_MAX) |=> code_q == CODE_MAX);
    a_r5_no_wrap_bot: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && !go_up && code_q == CODE_MIN) |=> code_q == CODE_MIN);
endmodule

// File: rtl/margin_trim_ctrl.sv
`timescale 1ns/1ps
module margin_trim_ctrl
    import mtc_pkg::*;
#(
    parameter int ADC_W = 10,
    parameter int DAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_up_i,
    input  logic             pin_dn_i,
    input  logic [1:0]       margin_cmd_i,
    input  logic [ADC_W-1:0] tgt_hi_i,
    input  logic [ADC_W-1:0] tgt_lo_i,
    input  logic [DAC_W-1:0] start_code_i,
    input  logic             trim_inv_i,
    input  logic             ready_pol_i,
    input  logic             adc_valid_i,
    input  logic [ADC_W-1:0] adc_data_i,
    output logic             adc_ready_o,
    output logic [DAC_W-1:0] dac_code_o,
    output logic             trim_oe_o,
    output logic             ready_o
);
    mtc_state_e       state_q, state_d;
    mtc_dir_e         dir, dir_q;
    logic [ADC_W-1:0] tgt_sel;
    logic [ADC_W-1:0] held_q;
    logic             accept;
    logic             match;
    logic             go_up;
    logic             load;
    logic             step_en;

    mtc_req_arb #(.ADC_W(ADC_W)) u_arb (
        .pin_up  (pin_up_i),
        .pin_dn  (pin_dn_i),
        .cmd     (margin_cmd_i),
        .tgt_hi  (tgt_hi_i),
        .tgt_lo  (tgt_lo_i),
        .dir     (dir),
        .tgt_sel (tgt_sel)
    );

    assign accept  = adc_valid_i && (state_q == ST_SEEK);
    assign load    = (state_q == ST_IDLE) && (dir != DIR_NONE);
    assign step_en = accept && (dir != DIR_NONE) && !match;

    mtc_code_step #(.DAC_W(DAC_W), .ADC_W(ADC_W)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_code (start_code_i),
        .step_en    (step_en),
        .sample     (adc_data_i),
        .target     (tgt_sel),
        .inv        (trim_inv_i),
        .code       (dac_code_o),
        .match      (match),
        .go_up      (go_up)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (dir != DIR_NONE) state_d = ST_SEEK;            // start
            ST_SEEK: begin
                if (dir == DIR_NONE)        state_d = ST_IDLE;          // release
                else if (accept && match)   state_d = ST_HOLD;          // lock
            end
            ST_HOLD: begin
                if (dir == DIR_NONE)        state_d = ST_IDLE;          // release
                else if (dir != dir_q || tgt_sel != held_q)
                                            state_d = ST_SEEK;          // retarget
            end
            default:                        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_NONE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (dir != DIR_NONE) dir_q <= dir;
            if (state_q == ST_SEEK && accept && match && dir != DIR_NONE)
                held_q <= tgt_sel;
        end
    end

    // outputs
    always_comb begin
        trim_oe_o   = (state_q != ST_IDLE);
        adc_ready_o = (state_q == ST_SEEK);
        ready_o     = ready_pol_i ? (state_q == ST_HOLD) : (state_q != ST_HOLD);
    end

    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && dir != DIR_NONE) |=> (trim_oe_o && dac_code_o == $past(start_code_i)));
    a_r3_no_sample_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEEK && !adc_valid_i) |=> $stable(dac_code_o));
    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(dac_code_o));
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == DIR_NONE) |=> !trim_oe_o);
    a_r9_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_up_i && pin_dn_i) |=> !trim_oe_o);
    a_r6_no_accept_outside_seek: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SEEK) |-> !adc_ready_o);
endmodule

// File: tb/sim_margin_trim_ctrl.sv
`timescale 1ns/1ps
module sim_margin_trim_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_up = 1'b0, pin_dn = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [9:0] tgt_hi = 10'd600, tgt_lo = 10'd400;
    logic [7:0] start_code = 8'd128;
    logic       trim_inv = 1'b0, ready_pol = 1'b1;
    logic       adc_valid = 1'b0;
    logic [9:0] adc_data = '0;
    logic       adc_ready;
    logic [7:0] dac_code;
    logic       trim_oe, ready;

    int errors = 0;
    int checks = 0;

    // model state: 0 idle, 1 seek, 2 hold
    int       m_state = 0;
    int       m_dir = 0;
    logic [7:0] m_code = '0;
    logic [9:0] m_held = '0;

    always #10 clk = ~clk;

    margin_trim_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_up_i(pin_up), .pin_dn_i(pin_dn),
        .margin_cmd_i(cmd), .tgt_hi_i(tgt_hi), .tgt_lo_i(tgt_lo),
        .start_code_i(start_code), .trim_inv_i(trim_inv), .ready_pol_i(ready_pol),
        .adc_valid_i(adc_valid), .adc_data_i(adc_data), .adc_ready_o(adc_ready),
        .dac_code_o(dac_code), .trim_oe_o(trim_oe), .ready_o(ready)
    );

    function automatic int dir_of(logic u, logic d, logic [1:0] c);
        logic wu, wd;
        wu = u | (c == 2'b01);
        wd = d | (c == 2'b10);
        if (wu && !wd) return 1;
        if (wd && !wu) return 2;
        return 0;
    endfunction

    function automatic logic [10:0] expect_vec();
        logic rdy;
        rdy = ready_pol ? (m_state == 2) : (m_state != 2);
        return {m_state != 0, m_code, rdy, m_state == 1};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // advance one clock, update the model, compare at the falling edge
    task automatic cyc(string tag);
        int d;
        logic [9:0] tg;
        @(posedge clk);
        d  = dir_of(pin_up, pin_dn, cmd);
        tg = (d == 2) ? tgt_lo : tgt_hi;
        case (m_state)
            0: if (d != 0) begin m_state = 1; m_code = start_code; end
            1: if (d == 0) m_state = 0;
               else if (adc_valid) begin
                   if (adc_data == tg) begin m_state = 2; m_held = tg; end
                   else if ((adc_data < tg) ^ trim_inv) begin
                       if (m_code != 8'hFF) m_code = m_code + 1'b1;
                   end else begin
                       if (m_code != 8'h00) m_code = m_code - 1'b1;
                   end
               end
            default: if (d == 0) m_state = 0;
                     else if (d != m_dir || tg != m_held) m_state = 1;
        endcase
        if (d != 0) m_dir = d;
        @(negedge clk);
        check(tag, {21'd0, trim_oe, dac_code, ready, adc_ready}, {21'd0, expect_vec()});
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        #35 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {28'd0, trim_oe, ready, adc_ready, 1'b0}, 32'd0);
        check("R1 code", {24'd0, dac_code}, 32'd0);

        // R2 start by raise pin, R11 high target, R3 stepping up
        pin_up = 1'b1;
        cyc("R2");
        check("R2 load", {24'd0, dac_code}, 32'd128);
        adc_valid = 1'b1; adc_data = 10'd500;
        run("R3", 5);
        check("R3 up", {24'd0, dac_code}, 32'd133);
        adc_valid = 1'b0;
        run("R3 idle sample", 3);
        adc_valid = 1'b1; adc_data = 10'd700;
        run("R3 down", 2);
        check("R3 down", {24'd0, dac_code}, 32'd131);
        // R6 lock on equality, samples ignored in HOLD
        adc_data = 10'd600;
        cyc("R6");
        adc_data = 10'd10;
        run("R6 ignored", 4);
        check("R6 frozen", {24'd0, dac_code}, 32'd131);
        check("R7 active high", {31'd0, ready}, 32'd1);
        ready_pol = 1'b0;
        cyc("R7");
        check("R7 active low", {31'd0, ready}, 32'd0);
        ready_pol = 1'b1;
        // R10 retarget on target change
        tgt_hi = 10'd620;
        cyc("R10");
        check("R10 seek", {31'd0, adc_ready}, 32'd1);
        check("R10 kept", {24'd0, dac_code}, 32'd131);
        adc_data = 10'd620;
        cyc("R10 lock");
        // R8 release
        pin_up = 1'b0;
        adc_valid = 1'b0;
        cyc("R8");
        check("R8 hiz", {31'd0, trim_oe}, 32'd0);
        // R9 both pins
        pin_up = 1'b1; pin_dn = 1'b1;
        run("R9", 3);
        check("R9 idle", {31'd0, trim_oe}, 32'd0);
        pin_up = 1'b0;
        cmd = 2'b01;
        run("R9 pin+cmd", 2);
        check("R9 pin+cmd", {31'd0, trim_oe}, 32'd0);
        pin_dn = 1'b0;
        cmd = 2'b10;   // R11 lower command selects low target
        start_code = 8'd20;
        trim_inv = 1'b1;   // R4
        cyc("R11");
        adc_valid = 1'b1; adc_data = 10'd300;
        run("R4", 3);
        check("R4 inverted", {24'd0, dac_code}, 32'd17);
        run("R5 floor", 30);
        check("R5 floor", {24'd0, dac_code}, 32'd0);
        cmd = 2'b00; adc_valid = 1'b0;
        cyc("R8 cmd");
        trim_inv = 1'b0; start_code = 8'd250; cmd = 2'b01;
        cyc("R2 cmd");
        adc_valid = 1'b1; adc_data = 10'd0;
        run("R5 ceil", 12);
        check("R5 ceil", {24'd0, dac_code}, 32'd255);
        cmd = 2'b11;
        cyc("R11 none");
        check("R11 cmd 11", {31'd0, trim_oe}, 32'd0);
        cmd = 2'b00;

        // random phase
        start_code = 8'd128;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 29) == 0) begin
                pin_up = ($urandom_range(0, 2) == 0);
                pin_dn = ($urandom_range(0, 2) == 0);
                cmd    = 2'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 199) == 0) tgt_hi = 10'($urandom_range(500, 700));
            if ($urandom_range(0, 199) == 0) tgt_lo = 10'($urandom_range(300, 499));
            if ($urandom_range(0, 299) == 0) trim_inv = ~trim_inv;
            if ($urandom_range(0, 299) == 0) ready_pol = ~ready_pol;
            if ($urandom_range(0, 99) == 0) start_code = 8'($urandom_range(0, 255));
            adc_valid = ($urandom_range(0, 1) == 1);
            begin
                int base;
                base = (dir_of(pin_up, pin_dn, cmd) == 2) ? int'(tgt_lo) : int'(tgt_hi);
                adc_data = 10'(base + $urandom_range(0, 6) - 3);
            end
            cyc("R10 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule